// File: doc/BRIEF.md
# SDRAM Command Timing and Refresh Scheduler

This block sits between a memory controller's command queue and the pins of a four-bank synchronous DRAM. Each cycle the queue presents at most one command (row open, column read, column write, single-bank close, close-all, auto-refresh or mode-register load) together with a bank number. In the same cycle the scheduler either grants the command or stalls it. A command is granted only when every minimum spacing rule that applies to it is met. The scheduler keeps, for each bank, an open/closed flag and countdown timers for row-to-column delay, minimum open time, write recovery, close recovery and row cycle. Shared countdowns cover open-to-open spacing across banks, refresh recovery and the quiet period after a mode-register load.

All limits are given in picoseconds together with the clock period, and they are converted into clock counts at elaboration. Minimum times are rounded up. The refresh interval and the maximum open time are rounded down, so that the deadlines are always met. A free-running interval timer adds one to a small saturating backlog of owed refreshes. While any refresh is owed, new row opens are held back, so that the controller closes its banks and issues the refresh. A bank that has stayed open close to its maximum open time raises a forced-close request.

Top module: `sdr_sched`

## Requirements
- R1: Each minimum time becomes ceil(time / period) clocks. With the defaults (7.5 ns clock) these are: open-to-open across banks 2, open-to-column 3, close recovery 3, minimum open time 6, row cycle 9. Write recovery is 2 clocks and the mode-load gap is 2 clocks. The refresh interval is floor(7.8125 us / 7.5 ns) = 1041 clocks, and the maximum open time is floor(100 us / 7.5 ns) = 13333 clocks.
- R2: req_cmd encodes 0 idle, 1 open row, 2 read, 3 write, 4 close bank, 5 close all, 6 refresh, 7 mode load, and req_bank selects the bank. req_grant is high in the same cycle when req_valid is high and the command is legal. req_stall is high when req_valid is high, the command is not idle and it is not granted. Neither output is ever high together with the other, and both stay low when req_valid is low.
- R3: A read or write is granted only to an open bank, and no earlier than 3 clocks after that bank's open.
- R4: An open is granted only to a closed bank. It must come at least 3 clocks after that bank's close, at least 9 clocks after that bank's previous open, and at least 2 clocks after an open to any bank. A granted open sets bit b of bank_open from the next cycle.
- R5: Closing an open bank is granted at least 6 clocks after its open and at least 2 clocks after its last write. Closing a bank that is already closed is granted and changes no state. Close-all is granted only when every open bank meets the close rule, and it clears bank_open.
- R6: A refresh or mode load is granted only when all banks are closed and every bank's close lies at least 3 clocks back. After a refresh, another refresh, an open or a mode load must wait at least 9 clocks.
- R7: For one clock after a granted mode load, no command is granted. The next command may be granted 2 clocks after the mode load.
- R8: refresh_backlog counts up by one every 1041 clocks after reset, saturates at 7, and drops by one for each granted refresh (never below 0). refresh_due is high whenever the backlog is nonzero.
- R9: While refresh_due is high, opens stall. Reads, writes and closes are still granted under their own rules.
- R10: force_pre[b] goes high once bank b has been open for 13325 clocks (the maximum open time less a lead of 8), counting the open's own edge as clock 1. It stays high until the bank is closed, and it is never high for a closed bank.
- R11: After reset all banks are closed, the backlog is 0, and refresh_due, force_pre and req_grant are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_cmd | input | 3 | Command code (see R2) |
| req_bank | input | 2 | Target bank |
| req_grant | output | 1 | Command accepted this cycle |
| req_stall | output | 1 | Command held back this cycle |
| bank_open | output | 4 | One bit per bank, high while its row is open |
| force_pre | output | 4 | Per-bank request to close before the open-time limit |
| refresh_due | output | 1 | At least one refresh is owed |
| refresh_backlog | output | 3 | Number of owed refreshes |

## Verification
The bound checker watches every cycle for these properties: no read or write goes to a closed bank, no open goes to an open bank, refresh and mode load are granted only when all banks are idle, the cycle after a mode load or an open is quiet in the ways required, the backlog never jumps by more than one, and opens never pass while a refresh is owed. The exact clock distances, such as the third cycle after an open being the first legal read or a close landing two cycles after a write, can be shown only by the bench. The same holds for the phase of the refresh tick, backlog saturation and the moment the forced-close request rises. The bench does this with directed sequences and with a long random run compared against a timestamp model.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_OPEN  = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_CLOSE = 3'd4,
        CMD_CLALL = 3'd5,
        CMD_REF   = 3'd6,
        CMD_MODE  = 3'd7
    } sched_cmd_e;

    // minimum spacing: round up to whole clocks
    function automatic int ps_to_clk_up(input int t_ps, input int p_ps);
        return (t_ps + p_ps - 1) / p_ps;
    endfunction

    // deadline: round down so the limit is never exceeded
    function automatic int ps_to_clk_down(input int t_ps, input int p_ps);
        return t_ps / p_ps;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer
    import sdr_sched_pkg::*;
#(
    parameter int RCD_CLK  = 3,
    parameter int RAS_CLK  = 6,
    parameter int RP_CLK   = 3,
    parameter int RC_CLK   = 9,
    parameter int WR_CLK   = 2,
    parameter int FORCE_AT = 13325
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic wr_i,
    input  logic close_i,
    output logic open_o,
    output logic col_ok_o,
    output logic act_ok_o,
    output logic pre_ok_o,
    output logic idle_ok_o,
    output logic force_pre_o
);

    localparam int CNT_MAX = max2(max2(RCD_CLK, RAS_CLK), max2(max2(RP_CLK, RC_CLK), WR_CLK));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int AW      = $clog2(FORCE_AT + 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rp;
        logic [CW-1:0] rc;
        logic [AW-1:0] age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dec(st_q.rcd);
        st_d.ras = dec(st_q.ras);
        st_d.rp  = dec(st_q.rp);
        st_d.rc  = dec(st_q.rc);

        if (act_i) begin
            st_d.open = 1'b1;
            st_d.rcd  = CW'(RCD_CLK - 1);
            st_d.ras  = CW'(RAS_CLK - 1);
            st_d.rc   = CW'(RC_CLK - 1);
            st_d.age  = AW'(1);
        end else if (st_q.open && (st_q.age < AW'(FORCE_AT))) begin
            st_d.age = st_q.age + 1'b1;
        end

        if (wr_i && (st_d.ras < CW'(WR_CLK - 1))) begin
            st_d.ras = CW'(WR_CLK - 1);
        end

        if (close_i) begin
            st_d.open = 1'b0;
            st_d.rp   = CW'(RP_CLK - 1);
            st_d.age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o      = st_q.open;
    assign col_ok_o    = st_q.open && (st_q.rcd == '0);
    assign act_ok_o    = !st_q.open && (st_q.rp == '0) && (st_q.rc == '0);
    assign pre_ok_o    = !st_q.open || (st_q.ras == '0);
    assign idle_ok_o   = !st_q.open && (st_q.rp == '0);
    assign force_pre_o = st_q.open && (st_q.age >= AW'(FORCE_AT));

endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
    parameter int REFI_CLK = 1041,
    parameter int PEND_MAX = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ref_done_i,
    output logic [$clog2(PEND_MAX+1)-1:0]   backlog_o,
    output logic                            due_o
);

    localparam int RW = $clog2(REFI_CLK + 1);
    localparam int PW = $clog2(PEND_MAX + 1);

    typedef struct packed {
        logic [RW-1:0] refi;
        logic [PW-1:0] pend;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.refi == '0);
        st_d.refi = tick ? RW'(REFI_CLK - 1) : st_q.refi - 1'b1;

        if (tick && !ref_done_i) begin
            if (st_q.pend < PW'(PEND_MAX)) begin
                st_d.pend = st_q.pend + 1'b1;
            end
        end else if (ref_done_i && !tick) begin
            if (st_q.pend != '0) begin
                st_d.pend = st_q.pend - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.refi <= RW'(REFI_CLK - 1);
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign backlog_o = st_q.pend;
    assign due_o     = (st_q.pend != '0);

endmodule

// File: rtl/sdr_sched.sv
module sdr_sched
    import sdr_sched_pkg::*;
#(
    parameter int BANKS         = 4,
    parameter int CLK_PS        = 7500,
    parameter int T_RRD_PS      = 15000,
    parameter int T_RCD_PS      = 20000,
    parameter int T_RP_PS       = 20000,
    parameter int T_RAS_PS      = 45000,
    parameter int T_RAS_MAX_PS  = 100_000_000,
    parameter int T_RC_PS       = 65000,
    parameter int T_REFI_PS     = 7_812_500,
    parameter int WR_CLK        = 2,
    parameter int MRS_CLK       = 2,
    parameter int FORCE_LEAD    = 8,
    parameter int PEND_MAX      = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [2:0]                    req_cmd,
    input  logic [$clog2(BANKS)-1:0]      req_bank,
    output logic                          req_grant,
    output logic                          req_stall,
    output logic [BANKS-1:0]              bank_open,
    output logic [BANKS-1:0]              force_pre,
    output logic                          refresh_due,
    output logic [$clog2(PEND_MAX+1)-1:0] refresh_backlog
);

    localparam int RRD_CLK     = at_least_one(ps_to_clk_up(T_RRD_PS, CLK_PS));
    localparam int RCD_CLK     = at_least_one(ps_to_clk_up(T_RCD_PS, CLK_PS));
    localparam int RP_CLK      = at_least_one(ps_to_clk_up(T_RP_PS, CLK_PS));
    localparam int RAS_CLK     = at_least_one(ps_to_clk_up(T_RAS_PS, CLK_PS));
    localparam int RC_CLK      = at_least_one(ps_to_clk_up(T_RC_PS, CLK_PS));
    localparam int RAS_MAX_CLK = ps_to_clk_down(T_RAS_MAX_PS, CLK_PS);
    localparam int REFI_CLK    = at_least_one(ps_to_clk_down(T_REFI_PS, CLK_PS));
    localparam int FORCE_AT    = at_least_one(RAS_MAX_CLK - FORCE_LEAD);
    localparam int WRC         = at_least_one(WR_CLK);
    localparam int MRC         = at_least_one(MRS_CLK);
    localparam int GW          = $clog2(max2(max2(RRD_CLK, RC_CLK), MRC) + 1);

    typedef struct packed {
        logic [GW-1:0] rrd;
        logic [GW-1:0] rfc;
        logic [GW-1:0] mrd;
    } glob_st_t;

    glob_st_t   g_d, g_q;
    sched_cmd_e cmd;
    logic       grant;
    logic       ref_done;

    logic [BANKS-1:0] act_ok, col_ok, pre_ok, idle_ok;
    logic [BANKS-1:0] do_act, do_wr, do_close;

    function automatic logic [GW-1:0] gdec(input logic [GW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        logic quiet;
        cmd   = sched_cmd_e'(req_cmd);
        quiet = (g_q.mrd == '0);
        g_d     = g_q;
        g_d.rrd = gdec(g_q.rrd);
        g_d.rfc = gdec(g_q.rfc);
        g_d.mrd = gdec(g_q.mrd);

        case (cmd)
            CMD_OPEN:  grant = act_ok[req_bank] && (g_q.rrd == '0) && (g_q.rfc == '0)
                               && quiet && !refresh_due;
            CMD_RD,
            CMD_WR:    grant = col_ok[req_bank] && quiet;
            CMD_CLOSE: grant = pre_ok[req_bank] && quiet;
            CMD_CLALL: grant = (&pre_ok) && quiet;
            CMD_REF,
            CMD_MODE:  grant = (&idle_ok) && (g_q.rfc == '0) && quiet;
            default:   grant = 1'b0;
        endcase
        grant = grant && req_valid;

        if (grant && (cmd == CMD_OPEN)) g_d.rrd = GW'(RRD_CLK - 1);
        if (grant && (cmd == CMD_REF))  g_d.rfc = GW'(RC_CLK - 1);
        if (grant && (cmd == CMD_MODE)) g_d.mrd = GW'(MRC - 1);

        ref_done = grant && (cmd == CMD_REF);

        for (int i = 0; i < BANKS; i++) begin
            do_act[i]   = grant && (cmd == CMD_OPEN) && (req_bank == i[$clog2(BANKS)-1:0]);
            do_wr[i]    = grant && (cmd == CMD_WR) && (req_bank == i[$clog2(BANKS)-1:0]);
            do_close[i] = grant && bank_open[i] &&
                          (((cmd == CMD_CLOSE) && (req_bank == i[$clog2(BANKS)-1:0])) ||
                           (cmd == CMD_CLALL));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            sdr_bank_timer #(
                .RCD_CLK (RCD_CLK),
                .RAS_CLK (RAS_CLK),
                .RP_CLK  (RP_CLK),
                .RC_CLK  (RC_CLK),
                .WR_CLK  (WRC),
                .FORCE_AT(FORCE_AT)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .act_i      (do_act[b]),
                .wr_i       (do_wr[b]),
                .close_i    (do_close[b]),
                .open_o     (bank_open[b]),
                .col_ok_o   (col_ok[b]),
                .act_ok_o   (act_ok[b]),
                .pre_ok_o   (pre_ok[b]),
                .idle_ok_o  (idle_ok[b]),
                .force_pre_o(force_pre[b])
            );
        end
    endgenerate

    sdr_refresh_tracker #(
        .REFI_CLK(REFI_CLK),
        .PEND_MAX(PEND_MAX)
    ) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_done_i(ref_done),
        .backlog_o (refresh_backlog),
        .due_o     (refresh_due)
    );

    assign req_grant = grant;
    assign req_stall = req_valid && (cmd != CMD_IDLE) && !grant;

endmodule

// File: rtl/sdr_sched_chk.sv
module sdr_sched_chk #(
    parameter int BANKS    = 4,
    parameter int PEND_MAX = 7,
    parameter int RRD_CLK  = 2,
    parameter int MRS_CLK  = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [2:0]                    req_cmd,
    input logic [$clog2(BANKS)-1:0]      req_bank,
    input logic                          req_grant,
    input logic                          req_stall,
    input logic [BANKS-1:0]              bank_open,
    input logic [BANKS-1:0]              force_pre,
    input logic                          refresh_due,
    input logic [$clog2(PEND_MAX+1)-1:0] refresh_backlog
);

    // R2
    grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && req_stall));

    // R2
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> req_valid);

    // R3
    col_to_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && ((req_cmd == 3'd2) || (req_cmd == 3'd3))) |-> bank_open[req_bank]);

    // R4
    open_to_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && (req_cmd == 3'd1)) |-> !bank_open[req_bank]);

    // R4
    open_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && (req_cmd == 3'd1)) |=> bank_open[$past(req_bank)]);

    generate
        if (RRD_CLK > 1) begin : g_rrd
            // R4
            open_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_grant && (req_cmd == 3'd1)) |=> !(req_grant && (req_cmd == 3'd1)));
        end
        if (MRS_CLK > 1) begin : g_mrd
            // R7
            mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_grant && (req_cmd == 3'd7)) |=> !req_grant);
        end
    endgenerate

    // R5
    close_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && (req_cmd == 3'd5)) |=> (bank_open == '0));

    // R6
    ref_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && ((req_cmd == 3'd6) || (req_cmd == 3'd7))) |-> (bank_open == '0));

    // R8
    backlog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_backlog > $past(refresh_backlog)) |->
            (refresh_backlog == $past(refresh_backlog) + 1'b1));

    // R9
    due_blocks_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |-> !(req_grant && (req_cmd == 3'd1)));

    // R10
    force_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_pre & ~bank_open) == '0);

endmodule

bind sdr_sched sdr_sched_chk #(
    .BANKS   (BANKS),
    .PEND_MAX(PEND_MAX),
    .RRD_CLK (RRD_CLK),
    .MRS_CLK (MRC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_cmd        (req_cmd),
    .req_bank       (req_bank),
    .req_grant      (req_grant),
    .req_stall      (req_stall),
    .bank_open      (bank_open),
    .force_pre      (force_pre),
    .refresh_due    (refresh_due),
    .refresh_backlog(refresh_backlog)
);

// File: tb/sdr_sched_test.sv
`timescale 1ns/1ps
module sdr_sched_test;

    localparam int T_RRD = 2, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9;
    localparam int T_WR = 2, T_MRD = 2, T_REFI = 1041, FORCE_AT = 13325, CAP = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_grant, req_stall, refresh_due;
    logic [3:0] bank_open, force_pre;
    logic [2:0] refresh_backlog;

    sdr_sched uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_grant(req_grant), .req_stall(req_stall),
        .bank_open(bank_open), .force_pre(force_pre), .refresh_due(refresh_due),
        .refresh_backlog(refresh_backlog)
    );

    always #5 clk = ~clk;

    int nchk = 0, nerr = 0, ecount = 0;
    bit done = 1'b0;

    // timestamp model
    int  lact[4], lpre[4], lwr[4];
    bit  mopen[4];
    int  lact_any, lref, lmrs, pend;

    task automatic chk(input int act, input int exp, input string what);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", what, act, exp, ecount);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            1:       return "R4 open";
            2, 3:    return "R3 column";
            4, 5:    return "R5 close";
            6:       return "R6 refresh";
            7:       return "R6 mode";
            default: return "R2 idle";
        endcase
    endfunction

    function automatic bit model_grant(input int c, input int b, input int e);
        bit q = (e - lmrs) >= T_MRD;
        bit ok;
        case (c)
            1: return q && !mopen[b] && (e - lpre[b] >= T_RP) && (e - lact[b] >= T_RC)
                      && (e - lact_any >= T_RRD) && (e - lref >= T_RC) && (pend == 0);
            2, 3: return q && mopen[b] && (e - lact[b] >= T_RCD);
            4: return q && (!mopen[b] || ((e - lact[b] >= T_RAS) && (e - lwr[b] >= T_WR)));
            5: begin
                ok = q;
                for (int i = 0; i < 4; i++)
                    if (mopen[i] && !((e - lact[i] >= T_RAS) && (e - lwr[i] >= T_WR))) ok = 0;
                return ok;
            end
            6, 7: begin
                ok = q && (e - lref >= T_RC);
                for (int i = 0; i < 4; i++)
                    if (mopen[i] || (e - lpre[i] < T_RP)) ok = 0;
                return ok;
            end
            default: return 0;
        endcase
    endfunction

    task automatic check_state();
        int ov = 0, fv = 0;
        for (int i = 0; i < 4; i++) begin
            ov |= int'(mopen[i]) << i;
            if (mopen[i] && (ecount - lact[i] + 1 >= FORCE_AT)) fv |= 1 << i;
        end
        chk(int'(bank_open), ov, "R4 bank_open");
        chk(int'(refresh_backlog), pend, "R8 backlog");
        chk(int'(refresh_due), int'(pend != 0), "R8 due");
        chk(int'(force_pre), fv, "R10 force_pre");
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic issue(input int c, input int b, input int exp, input string tag);
        int  e;
        bit  m, did_ref;
        req_valid = (c != 0);
        req_cmd   = 3'(c);
        req_bank  = 2'(b);
        #1;
        e = ecount + 1;
        m = model_grant(c, b, e);
        chk(int'(req_grant), int'(m), tag_of(c));
        chk(int'(req_stall), int'((c != 0) && !m), "R2 stall");
        if (exp >= 0) chk(int'(req_grant), exp, tag);
        @(posedge clk);
        ecount++;
        did_ref = 0;
        if (m) begin
            case (c)
                1: begin mopen[b] = 1; lact[b] = e; lact_any = e; end
                3: lwr[b] = e;
                4: if (mopen[b]) begin mopen[b] = 0; lpre[b] = e; end
                5: for (int i = 0; i < 4; i++)
                       if (mopen[i]) begin mopen[i] = 0; lpre[i] = e; end
                6: begin lref = e; did_ref = 1; end
                7: lmrs = e;
                default: ;
            endcase
        end
        if ((e % T_REFI == 0) && !did_ref) begin
            if (pend < CAP) pend++;
        end else if (did_ref && (e % T_REFI != 0)) begin
            if (pend > 0) pend--;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check_state();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 0, -1, "R2 idle");
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ecount, 34000);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        for (int i = 0; i < 4; i++) begin
            lact[i] = -1000; lpre[i] = -1000; lwr[i] = -1000; mopen[i] = 0;
        end
        lact_any = -1000; lref = -1000; lmrs = -1000; pend = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk(int'(bank_open), 0, "R11 bank_open");
        chk(int'(refresh_backlog), 0, "R11 backlog");
        chk(int'(refresh_due), 0, "R11 due");
        chk(int'(force_pre), 0, "R11 force");
        chk(int'(req_grant), 0, "R11 grant");

        // R1 / R3 / R4 / R5 directed spacing
        issue(1, 0, 1, "R4 open bank0");             // E1
        issue(1, 1, 0, "R1 R4 open-open 1 clk");     // E2
        issue(2, 0, 0, "R1 R3 read 2 clk");          // E3
        issue(2, 0, 1, "R1 R3 read 3 clk");          // E4
        issue(1, 1, 1, "R4 open bank1");             // E5
        issue(3, 0, 1, "R3 write");                  // E6
        issue(4, 0, 0, "R5 close 1 after write");    // E7
        issue(4, 0, 1, "R1 R5 close 2 after write"); // E8
        issue(1, 0, 0, "R4 reopen 1 after close");   // E9
        issue(1, 0, 0, "R4 reopen 2 after close");   // E10
        issue(1, 0, 1, "R1 R4 reopen 3 after close");// E11
        issue(2, 2, 0, "R3 read closed bank");       // E12
        issue(4, 3, 1, "R5 close closed bank");      // E13
        chk(int'(bank_open), 4'b0011, "R5 closed-bank close no effect");
        issue(6, 0, 0, "R6 refresh with open banks");// E14
        issue(5, 0, 0, "R5 close-all early");        // E15
        idle(2);                                     // E16-17
        issue(5, 0, 1, "R5 close-all");              // E18
        issue(6, 0, 0, "R6 refresh 1 after close");  // E19
        issue(6, 0, 0, "R6 refresh 2 after close");  // E20
        issue(6, 0, 1, "R6 refresh 3 after close");  // E21
        issue(7, 0, 0, "R6 mode inside refresh");    // E22
        idle(7);                                     // E23-29
        issue(7, 0, 1, "R6 mode 9 after refresh");   // E30
        issue(4, 0, 0, "R7 quiet after mode");       // E31
        issue(1, 0, 1, "R7 open 2 after mode");      // E32

        // R8 / R10 long hold with bank0 open
        while (ecount < FORCE_AT + 31 - 1) begin
            issue(0, 0, -1, "R2 idle");
            if (ecount == T_REFI - 1) chk(int'(refresh_backlog), 0, "R8 before first tick");
            if (ecount == T_REFI)     chk(int'(refresh_backlog), 1, "R8 first tick");
        end
        chk(int'(force_pre[0]), 0, "R10 force one clk early");
        issue(0, 0, -1, "R2 idle");
        chk(int'(force_pre[0]), 1, "R10 force at limit");
        chk(int'(refresh_backlog), CAP, "R8 saturation");

        // R9 refresh owed: opens stall, column and close continue
        issue(1, 2, 0, "R9 open while due");
        issue(2, 0, 1, "R9 read while due");
        issue(4, 0, 1, "R9 close while due");
        chk(int'(force_pre[0]), 0, "R10 force cleared by close");
        idle(2);
        for (int k = 0; k < CAP; k++) begin
            issue(6, 0, 1, "R8 drain refresh");
            idle(T_RC - 1);
        end
        chk(int'(refresh_due), 0, "R8 backlog drained");

        // random traffic checked against the model
        for (int i = 0; i < 20000; i++) begin
            int c = $urandom_range(0, 7);
            int b = $urandom_range(0, 3);
            issue(c, b, -1, "R2 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule